// File: doc/BRIEF.md
# UART Baud Rate Generator

This block turns a reference clock into a one-cycle baud tick for a serial shifter. The path first passes through an optional divide-by-8 prescaler, then a 16-bit clock divisor that yields a sample tick, and then an 8-bit bit divisor that groups sample ticks into one bit time. The result is one baud tick every `presc × CD × (BD + 1)` reference cycles.

The two divisor registers live inside the block. Each has its own write strobe, and both share one 32-bit write-data bus. A write with an out-of-range value leaves the register unchanged. Any write strobe, accepted or not, restarts the whole divider chain, so the first tick after a write lands a full period later.

From the frame fields of the mode byte, the block also reports the length of one character in bit times. It reports the same length in sample ticks, for use by a receive timeout.

Top module: `uart_baud_gen`

## Requirements
- R1: After reset the clock divisor `cd_o` reads 0x28B and the bit divisor `bd_o` reads 0xF. With `mode_i[0]`=0 the first tick after reset release comes 10416 cycles later.
- R2: A `cd_we_i` write with `wdata_i` equal to 0 leaves `cd_o` unchanged. Any other value stores `wdata_i[15:0]`, so 0x12345 stores 0x2345.
- R3: A `bd_we_i` write with `wdata_i` below 4 leaves `bd_o` unchanged. Any other value stores `wdata_i[7:0]`, so 0x1FF stores 0xFF.
- R4: With `mode_i[0]`=0, consecutive `baud_tick_o` pulses are exactly `cd_o × (bd_o + 1)` cycles apart.
- R5: With `mode_i[0]`=1, the tick period is 8 × `cd_o` × (`bd_o` + 1) cycles.
- R6: `baud_tick_o` is high for single cycles. Every divisor write strobe restarts the chain, including an ignored one. The first tick then comes exactly one period after the clock edge that took the strobe, and no tick is seen on the cycle after that edge.
- R7: The data length field `mode_i[2:1]` decodes 3 as 6 bits, 2 as 7 bits, and 0 or 1 as 8 bits.
- R8: The parity field `mode_i[5:3]` adds one bit for values 0 (even) and 1 (odd). Values 2 to 7 add none.
- R9: The stop field `mode_i[7:6]` decodes 3 as 1 stop bit and any other value as 2. `char_bits_o` = 1 + parity bit + data bits + stop bits, which always lies in 8 to 12.
- R10: `char_span_o` = `char_bits_o` × (`bd_o` + 1), the character time in sample ticks. It follows `mode_i` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 8 | Bit 0 selects the divide-by-8 prescaler; bits 7:1 are the frame fields |
| cd_we_i | input | 1 | Clock divisor write strobe |
| bd_we_i | input | 1 | Bit divisor write strobe |
| wdata_i | input | 32 | Write data shared by both divisors |
| cd_o | output | 16 | Stored clock divisor |
| bd_o | output | 8 | Stored bit divisor |
| baud_tick_o | output | 1 | One-cycle pulse per bit time |
| char_bits_o | output | 4 | Character length in bit times |
| char_span_o | output | 13 | Character length in sample ticks |

## Verification
The counter-range assertions rely on one fact: a divisor changes only on the same edge that restarts its counters. That holds because the registers can be loaded only through the write strobes. The write-guard assertions assume that `wdata_i` is a defined value whenever a strobe is high. The bench therefore drives data together with each strobe, and it sets `mode_i[0]` before the divisor writes that start a prescaled run. It changes the frame fields only while no tick interval is awaited, so an expected period never spans a change of the prescaler select.

// File: rtl/baud_pkg.sv
package baud_pkg;
  typedef struct packed {
    logic [1:0] stop;
    logic [2:0] par;
    logic [1:0] len;
    logic       pre8;
  } mode_t;

  localparam int unsigned CHAR_W = 4;
endpackage

// File: rtl/baud_div_reg.sv
module baud_div_reg #(
  parameter int unsigned W   = 16,
  parameter int unsigned DW  = 32,
  parameter logic [W-1:0] RST = '0,
  parameter int unsigned MIN = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [W-1:0]  q_o
);
  logic accept;
  assign accept = we_i && (wdata_i >= DW'(MIN));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= RST;
    else if (accept) q_o <= wdata_i[W-1:0];
  end

  // guarded write leaves the register alone (R2 for cd, R3 for bd)
  assert_guard_hold_R2_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (wdata_i < DW'(MIN))) |=> $stable(q_o));

  assert_store_low_R2_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (wdata_i >= DW'(MIN))) |=> (q_o == $past(wdata_i[W-1:0])));
endmodule

// File: rtl/baud_tick_chain.sv
module baud_tick_chain #(
  parameter int unsigned CD_W    = 16,
  parameter int unsigned BD_W    = 8,
  parameter int unsigned PRE_DIV = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            pre8_i,
  input  logic            restart_i,
  input  logic [CD_W-1:0] cd_i,
  input  logic [BD_W-1:0] bd_i,
  output logic            tick_o
);
  localparam int unsigned PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;

  logic pre_tick;

  generate
    if (PRE_DIV > 1) begin : g_pre
      logic [PRE_W-1:0] pre_cnt;
      logic             pre_last;
      assign pre_last = (pre_cnt == PRE_W'(PRE_DIV - 1));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)        pre_cnt <= '0;
        else if (restart_i) pre_cnt <= '0;
        else if (pre_last)  pre_cnt <= '0;
        else                pre_cnt <= pre_cnt + 1'b1;
      end
      assign pre_tick = !pre8_i || pre_last;
    end else begin : g_nopre
      assign pre_tick = 1'b1;
    end
  endgenerate

  logic [CD_W-1:0] cd_cnt;
  logic            cd_last, cd_tick;
  assign cd_last = (cd_cnt == cd_i - CD_W'(1));
  assign cd_tick = pre_tick && cd_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cd_cnt <= '0;
    else if (restart_i) cd_cnt <= '0;
    else if (pre_tick)  cd_cnt <= cd_last ? '0 : cd_cnt + 1'b1;
  end

  logic [BD_W-1:0] bit_cnt;
  logic            bit_last;
  assign bit_last = (bit_cnt == bd_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        bit_cnt <= '0;
    else if (restart_i) bit_cnt <= '0;
    else if (cd_tick)   bit_cnt <= bit_last ? '0 : bit_cnt + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        tick_o <= 1'b0;
    else if (restart_i) tick_o <= 1'b0;
    else                tick_o <= cd_tick && bit_last;
  end

  assert_restart_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (bit_cnt == '0 && cd_cnt == '0 && !tick_o));

  assert_cd_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cd_i != '0) |-> (cd_cnt < cd_i));

  assert_bit_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_cnt <= bd_i);
endmodule

// File: rtl/baud_frame_len.sv
module baud_frame_len
  import baud_pkg::*;
#(
  parameter int unsigned BD_W   = 8,
  parameter int unsigned SPAN_W = CHAR_W + BD_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  mode_t             mode_i,
  input  logic [BD_W-1:0]   bd_i,
  output logic [CHAR_W-1:0] bits_o,
  output logic [SPAN_W-1:0] span_o
);
  logic [CHAR_W-1:0] data_bits, stop_bits, par_bits;
  logic [BD_W:0]     bd_p1;

  always_comb begin
    unique case (mode_i.len)
      2'b11:   data_bits = CHAR_W'(6);
      2'b10:   data_bits = CHAR_W'(7);
      default: data_bits = CHAR_W'(8);
    endcase
    par_bits  = (mode_i.par[2:1] == 2'b00) ? CHAR_W'(1) : CHAR_W'(0);
    stop_bits = (mode_i.stop == 2'b11) ? CHAR_W'(1) : CHAR_W'(2);
  end

  assign bits_o = CHAR_W'(1) + par_bits + data_bits + stop_bits;
  assign bd_p1  = {1'b0, bd_i} + 1'b1;
  assign span_o = SPAN_W'(bits_o) * SPAN_W'(bd_p1);

  assert_len_range_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bits_o >= CHAR_W'(8)) && (bits_o <= CHAR_W'(12)));
endmodule

// File: rtl/uart_baud_gen.sv
module uart_baud_gen
  import baud_pkg::*;
#(
  parameter int unsigned    REG_W   = 32,
  parameter int unsigned    CD_W    = 16,
  parameter int unsigned    BD_W    = 8,
  parameter int unsigned    PRE_DIV = 8,
  parameter logic [CD_W-1:0] CD_RST = 16'h028B,
  parameter logic [BD_W-1:0] BD_RST = 8'h0F,
  parameter int unsigned    BD_MIN  = 4,
  localparam int unsigned   SPAN_W  = CHAR_W + BD_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        mode_i,
  input  logic              cd_we_i,
  input  logic              bd_we_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [CD_W-1:0]   cd_o,
  output logic [BD_W-1:0]   bd_o,
  output logic              baud_tick_o,
  output logic [CHAR_W-1:0] char_bits_o,
  output logic [SPAN_W-1:0] char_span_o
);
  mode_t mode;
  assign mode = mode_t'(mode_i);

  baud_div_reg #(.W(CD_W), .DW(REG_W), .RST(CD_RST), .MIN(1)) u_cd_reg (
    .clk_i, .rst_ni, .we_i(cd_we_i), .wdata_i, .q_o(cd_o)
  );

  baud_div_reg #(.W(BD_W), .DW(REG_W), .RST(BD_RST), .MIN(BD_MIN)) u_bd_reg (
    .clk_i, .rst_ni, .we_i(bd_we_i), .wdata_i, .q_o(bd_o)
  );

  baud_tick_chain #(.CD_W(CD_W), .BD_W(BD_W), .PRE_DIV(PRE_DIV)) u_chain (
    .clk_i, .rst_ni,
    .pre8_i(mode.pre8),
    .restart_i(cd_we_i | bd_we_i),
    .cd_i(cd_o), .bd_i(bd_o),
    .tick_o(baud_tick_o)
  );

  baud_frame_len #(.BD_W(BD_W), .SPAN_W(SPAN_W)) u_frame (
    .clk_i, .rst_ni, .mode_i(mode), .bd_i(bd_o),
    .bits_o(char_bits_o), .span_o(char_span_o)
  );
endmodule

// File: tb/tb_uart_baud_gen.sv
`timescale 1ns/1ps
module tb_uart_baud_gen;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  mode = 8'h00;
  logic        cd_we = 1'b0, bd_we = 1'b0;
  logic [31:0] wdata = '0;
  logic [15:0] cd_o;
  logic [7:0]  bd_o;
  logic        tick;
  logic [3:0]  char_bits;
  logic [12:0] char_span;

  always #10 clk = ~clk;

  uart_baud_gen dut (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode), .cd_we_i(cd_we), .bd_we_i(bd_we),
    .wdata_i(wdata), .cd_o(cd_o), .bd_o(bd_o), .baud_tick_o(tick),
    .char_bits_o(char_bits), .char_span_o(char_span)
  );

  int checks = 0, bad = 0, cyc = 0, ref_cyc = 0;
  int    exp_q[$];
  string tag_q[$];
  logic  prev_tick = 1'b0;
  bit    done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // monitor: pops expected intervals as ticks appear
  always @(negedge clk) begin
    if (rst_ni && tick) begin
      if (exp_q.size() > 0) begin
        int    e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, cyc - ref_cyc, e);
        check({t, " R6 width"}, int'(prev_tick), 0);
      end
      ref_cyc = cyc;
    end
    prev_tick = tick;
  end

  task automatic wr(bit is_cd, int unsigned v);
    @(negedge clk);
    wdata = v;
    if (is_cd) cd_we = 1'b1; else bd_we = 1'b1;
    @(negedge clk);
    cd_we = 1'b0;
    bd_we = 1'b0;
    ref_cyc = cyc;
  endtask

  task automatic expect_ticks(int p, int n, string tag);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(p);
      tag_q.push_back(tag);
    end
    wait (exp_q.size() == 0);
  endtask

  task automatic frame(logic [7:0] m, int bits, int bdv, string tag);
    @(negedge clk);
    mode = m;
    #2;
    check({tag, " bits"}, int'(char_bits), bits);
    check("R10 span", int'(char_span), bits * (bdv + 1));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    bad++;
    $display("FAIL watchdog act=timeout exp=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    ref_cyc = cyc;
    #1;
    check("R1 cd reset", int'(cd_o), 'h28B);
    check("R1 bd reset", int'(bd_o), 'hF);
    expect_ticks(10416, 2, "R1 R4 default period");

    wr(1, 3); wr(0, 4);
    check("R2 cd=3", int'(cd_o), 3);
    check("R3 bd=4", int'(bd_o), 4);
    expect_ticks(15, 3, "R4 period 3x5");

    wr(1, 1);
    expect_ticks(5, 2, "R4 period 1x5");

    wr(1, 0);
    check("R2 zero ignored", int'(cd_o), 1);
    expect_ticks(5, 1, "R6 restart on ignored cd");

    wr(0, 3);
    check("R3 below 4 ignored", int'(bd_o), 4);
    expect_ticks(5, 1, "R6 restart on ignored bd");

    wr(1, 'h12345);
    check("R2 low 16 bits", int'(cd_o), 'h2345);
    wr(1, 7); wr(0, 9);
    expect_ticks(70, 2, "R4 period 7x10");

    wr(0, 'h1FF);
    check("R3 low 8 bits", int'(bd_o), 'hFF);
    wr(1, 1);
    expect_ticks(256, 2, "R4 period 1x256");

    @(negedge clk);
    mode = 8'h01;
    wr(1, 2); wr(0, 4);
    expect_ticks(80, 3, "R5 prescaled period");

    frame(8'h00, 12, 4, "R7 R8 R9 8/even/2");
    frame(8'hC6, 9, 4, "R7 R9 6/even/1");
    frame(8'hE4, 9, 4, "R7 R8 7/none/1");
    frame(8'hCE, 9, 4, "R8 6/odd/1");
    frame(8'h20, 11, 4, "R8 8/none/2");
    frame(8'hF6, 8, 4, "R9 6/none/1");
    frame(8'h8C, 11, 4, "R7 7/odd/2");
    wr(0, 9);
    frame(8'h8C, 11, 9, "R10 span bd=9");

    finish_run();
  end
endmodule